// File: doc/BRIEF.md
# Writeback Frame Capture Controller

This block sequences the capture of one frame of pixels into memory. Software programs a destination base address, a line pitch in bytes and the frame dimensions through a 32-bit register port. It then sets a start bit in the control register. The controller answers with a one-cycle frame-start pulse towards the pixel source. After that it turns every accepted 32-bit pixel into a write request with an address, data and byte strobes.

Pixel k of line n is written to base + n * pitch + 4 * k. A line is committed when `width` pixels have been accepted, and a progress register counts the committed lines. When the count reaches the programmed height, the busy flag drops and a one-cycle frame-end pulse is issued. If the interrupt enable bit is set, the interrupt line is then raised. An abort bit ends the frame at once and suppresses all further writes. A power-down bit blocks new starts. A debug bit repeats the frame-start pulse when a frame completes.

Top module: `wbcap_ctrl`

## Requirements
- R1: After reset, the base, pitch, dimension and progress registers read 0. The control register reads 0x544F0000, with byte mask bits 19:16 = 0xF and all other writable bits 0. `irq`, `wr_valid`, `frm_sof` and `frm_eof` are 0.
- R2: Register offsets: base 0x00, pitch 0x04, dimensions 0x08 (height in bits 31:16, width in bits 15:0), control 0x0C, progress 0x10 (read-only). Control bits 31:24 always read 0x54 and bits 23:22 always read 01. Start bit 0 and abort bit 14 always read 0, and bit 1 reads the busy flag.
- R3: A control write with bit 0 set, while idle and with bit 21 clear in the written word, sets busy on that clock edge and clears progress. It also gives `frm_sof` high for the following cycle. The same write while busy is ignored: progress, the line position and `frm_sof` are unchanged.
- R4: While busy, each `pix_valid` cycle gives `wr_valid` in the same cycle, with `wr_addr` = base + line * pitch + 4 * pixel-in-line, `wr_data` = `pix_data` and `wr_strb` = control bits 19:16.
- R5: Progress increments on the edge that accepts the last pixel of a line. Busy clears on the edge that makes progress equal the height, and `frm_eof` is high for the following cycle. With height 0, busy clears one cycle after the start.
- R6: A control write with bit 14 set while busy clears busy on that edge. It suppresses `wr_valid` in that same cycle and after it, keeps progress, and gives no `frm_eof`.
- R7: `irq` equals control bit 2 AND "a frame ended (completed or aborted) since the last start". Writing bit 2 as 0 drops it.
- R8: Control bit 21 reads back as written, and a start written with bit 21 set is ignored.
- R9: With control bit 15 set, a completing frame gives `frm_sof` high in the same cycle as `frm_eof`. An abort gives no such pulse.
- R10: Pixels offered while idle produce no write and leave progress unchanged. Base and pitch values that are not aligned are stored and used unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| pix_valid | input | 1 | Pixel present on `pix_data` |
| pix_data | input | 32 | Pixel word |
| frm_sof | output | 1 | One-cycle frame-start request to the source |
| frm_eof | output | 1 | One-cycle frame-complete pulse |
| wr_valid | output | 1 | Memory write request |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |
| wr_strb | output | 4 | Write byte strobes |
| irq | output | 1 | Interrupt, level |

## Verification
Most internal errors in this block show up as a wrong `wr_addr` on the very next accepted pixel. An accumulated line base that drifts by one pitch, or a pixel index that fails to wrap at the line end, is visible in the same cycle as the offending pixel. A line counter that misses or repeats a commit shows in the progress register and in the frame-end timing: busy and `frm_eof` change one line early or late, or never. Sequencing faults, such as a restart accepted while busy or an abort that lets one more write through, show at the ports within one cycle.

// File: rtl/wbcap_pkg.sv
package wbcap_pkg;

  localparam int REG_AW = 8;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] OFS_BASE  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_PITCH = 8'h04;
  localparam logic [REG_AW-1:0] OFS_DIM   = 8'h08;
  localparam logic [REG_AW-1:0] OFS_CTL   = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_PROG  = 8'h10;

  localparam int CB_START = 0;
  localparam int CB_IRQEN = 2;
  localparam int CB_STOP  = 14;
  localparam int CB_RESOF = 15;
  localparam int CB_MASK  = 16;
  localparam int CB_PDN   = 21;

  localparam logic [7:0] ID_TAG = 8'h54;
  localparam logic [1:0] ID_REV = 2'b01;

  typedef struct packed {
    logic       pdn;
    logic [3:0] mask;
    logic       resof;
    logic       irq_en;
  } ctl_t;

  // Byte address of a pixel, written as a direct product.
  function automatic logic [31:0] pix_addr(input logic [31:0] base,
                                           input logic [31:0] pitch,
                                           input logic [31:0] line,
                                           input logic [31:0] col);
    return base + pitch * line + (col << 2);
  endfunction

  // Control register read image.
  function automatic logic [31:0] ctl_word(input ctl_t c, input logic busy);
    return {ID_TAG, ID_REV, c.pdn, 1'b0, c.mask, c.resof,
            12'b0, c.irq_en, busy, 1'b0};
  endfunction

endpackage

// File: rtl/wbcap_regs.sv
module wbcap_regs
  import wbcap_pkg::*;
#(
  parameter int DIM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              busy,
  input  logic [DIM_W-1:0]  prog,
  output logic              go_req,
  output logic              abort_req,
  output logic [31:0]       base,
  output logic [31:0]       pitch,
  output logic [DIM_W-1:0]  width,
  output logic [DIM_W-1:0]  height,
  output ctl_t              ctl
);

  logic ctl_wr;

  assign ctl_wr    = reg_wen && (reg_addr == OFS_CTL);
  assign go_req    = ctl_wr && reg_wdata[CB_START] && !reg_wdata[CB_PDN];
  assign abort_req = ctl_wr && reg_wdata[CB_STOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base       <= '0;
      pitch      <= '0;
      width      <= '0;
      height     <= '0;
      ctl.pdn    <= 1'b0;
      ctl.mask   <= 4'hF;
      ctl.resof  <= 1'b0;
      ctl.irq_en <= 1'b0;
    end else if (reg_wen) begin
      case (reg_addr)
        OFS_BASE:  base  <= reg_wdata;
        OFS_PITCH: pitch <= reg_wdata;
        OFS_DIM: begin
          width  <= reg_wdata[DIM_W-1:0];
          height <= reg_wdata[16 +: DIM_W];
        end
        OFS_CTL: begin
          ctl.pdn    <= reg_wdata[CB_PDN];
          ctl.mask   <= reg_wdata[CB_MASK +: 4];
          ctl.resof  <= reg_wdata[CB_RESOF];
          ctl.irq_en <= reg_wdata[CB_IRQEN];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_BASE:  reg_rdata = base;
      OFS_PITCH: reg_rdata = pitch;
      OFS_DIM:   reg_rdata = {16'(height), 16'(width)};
      OFS_CTL:   reg_rdata = ctl_word(ctl, busy);
      OFS_PROG:  reg_rdata = 32'(prog);
      default:   reg_rdata = '0;
    endcase
  end

  // R8: a start carrying the power-down bit never becomes a start request
  a_r8_pdn_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[CB_PDN]) |-> !go_req);

endmodule

// File: rtl/wbcap_seq.sv
module wbcap_seq
  import wbcap_pkg::*;
#(
  parameter int DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_req,
  input  logic             abort_req,
  input  logic             pix_valid,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  input  logic [31:0]      base,
  input  logic [31:0]      pitch,
  input  logic             resof,
  output logic             busy,
  output logic             fin,
  output logic             accept,
  output logic [DIM_W-1:0] prog,
  output logic [DIM_W-1:0] col,
  output logic [31:0]      line_base,
  output logic             frm_sof,
  output logic             frm_eof
);

  logic             start;
  logic             stop;
  logic             line_end;
  logic             last_line;
  logic             done;
  logic [DIM_W:0]   prog_inc;

  assign prog_inc  = {1'b0, prog} + 1'b1;
  assign start     = go_req && !busy && !abort_req;
  assign stop      = busy && abort_req;
  assign accept    = busy && pix_valid && !abort_req && (prog < height);
  assign line_end  = accept && (col == width - 1'b1);
  assign last_line = line_end && (prog_inc == {1'b0, height});
  assign done      = busy && !abort_req && (last_line || (prog == height));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      fin       <= 1'b0;
      prog      <= '0;
      col       <= '0;
      line_base <= '0;
      frm_sof   <= 1'b0;
      frm_eof   <= 1'b0;
    end else begin
      frm_sof <= start || (done && resof);
      frm_eof <= done;
      if (start) begin
        busy      <= 1'b1;
        fin       <= 1'b0;
        prog      <= '0;
        col       <= '0;
        line_base <= base;
      end else begin
        if (done || stop) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
        if (accept) begin
          if (line_end) begin
            col       <= '0;
            prog      <= prog_inc[DIM_W-1:0];
            line_base <= line_base + pitch;
          end else begin
            col <= col + 1'b1;
          end
        end
      end
    end
  end

  // R3: an accepted start leaves the block busy with a cleared count
  a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (go_req && !busy && !abort_req) |=> (busy && prog == '0 && col == '0));

  // R3: a start while busy disturbs nothing
  a_r3_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go_req && !abort_req && !pix_valid && prog != height)
      |=> (busy && prog == $past(prog) && col == $past(col)));

  // R5: progress only ever steps by one line while capturing
  a_r5_prog_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (prog == $past(prog) || prog == $past(prog) + DIM_W'(1)));

  // R6: abort ends the frame on the same edge and freezes progress
  a_r6_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort_req) |=> (!busy && !frm_eof && prog == $past(prog)));

  // R7: the ended-frame flag is never set during a capture
  a_r7_fin_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !busy);

endmodule

// File: rtl/wbcap_wr.sv
module wbcap_wr
  import wbcap_pkg::*;
#(
  parameter int DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             busy,
  input  logic [31:0]      pix_data,
  input  logic [31:0]      line_base,
  input  logic [DIM_W-1:0] col,
  input  logic [DIM_W-1:0] prog,
  input  logic [3:0]       mask,
  input  logic [31:0]      base,
  input  logic [31:0]      pitch,
  output logic             wr_valid,
  output logic [31:0]      wr_addr,
  output logic [31:0]      wr_data,
  output logic [3:0]       wr_strb
);

  assign wr_valid = accept;
  assign wr_addr  = line_base + (32'(col) << 2);
  assign wr_data  = pix_data;
  assign wr_strb  = mask;

  // R4: accumulated line base agrees with the direct product
  a_r4_addr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr == pix_addr(base, pitch, 32'(prog), 32'(col))));

  // R10: no write request leaves an idle block
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid);

endmodule

// File: rtl/wbcap_ctrl.sv
module wbcap_ctrl
  import wbcap_pkg::*;
#(
  parameter int DIM_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wen,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        pix_valid,
  input  logic [31:0] pix_data,
  output logic        frm_sof,
  output logic        frm_eof,
  output logic        wr_valid,
  output logic [31:0] wr_addr,
  output logic [31:0] wr_data,
  output logic [3:0]  wr_strb,
  output logic        irq
);

  logic             go_req;
  logic             abort_req;
  logic             busy;
  logic             fin;
  logic             accept;
  logic [DIM_W-1:0] prog;
  logic [DIM_W-1:0] col;
  logic [DIM_W-1:0] width;
  logic [DIM_W-1:0] height;
  logic [31:0]      base;
  logic [31:0]      pitch;
  logic [31:0]      line_base;
  ctl_t             ctl;

  wbcap_regs #(.DIM_W(DIM_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .busy(busy), .prog(prog),
    .go_req(go_req), .abort_req(abort_req),
    .base(base), .pitch(pitch), .width(width), .height(height),
    .ctl(ctl)
  );

  wbcap_seq #(.DIM_W(DIM_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .go_req(go_req), .abort_req(abort_req), .pix_valid(pix_valid),
    .width(width), .height(height), .base(base), .pitch(pitch),
    .resof(ctl.resof),
    .busy(busy), .fin(fin), .accept(accept), .prog(prog), .col(col),
    .line_base(line_base), .frm_sof(frm_sof), .frm_eof(frm_eof)
  );

  wbcap_wr #(.DIM_W(DIM_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .busy(busy), .pix_data(pix_data),
    .line_base(line_base), .col(col), .prog(prog), .mask(ctl.mask),
    .base(base), .pitch(pitch),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_strb(wr_strb)
  );

  assign irq = ctl.irq_en && fin;

  // R7: the interrupt is only ever seen on an idle block
  a_r7_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);

  // R5: the frame-end pulse follows the edge on which busy dropped
  a_r5_eof_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    frm_eof |-> (!busy && $past(busy)));

endmodule

// File: tb/wbcap_ctrl_bench.sv
module wbcap_ctrl_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pix_valid = 1'b0;
  logic [31:0] pix_data = '0;
  logic        frm_sof, frm_eof, wr_valid, irq;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_strb;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  wbcap_ctrl u_wbcap_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .pix_valid(pix_valid), .pix_data(pix_data),
    .frm_sof(frm_sof), .frm_eof(frm_eof),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_strb(wr_strb), .irq(irq)
  );

  function automatic logic [31:0] want_addr(input logic [31:0] b, input logic [31:0] p,
                                            input int line, input int k);
    logic [31:0] a;
    a = b;
    for (int i = 0; i < line; i++) a = a + p;
    for (int i = 0; i < k; i++) a = a + 32'd4;
    return a;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic push(input logic [31:0] d, input logic [31:0] ea,
                      input logic [3:0] es, input string tag);
    pix_valid = 1'b1; pix_data = d;
    #1;
    chk({tag, " wr_valid"}, 32'(wr_valid), 32'd1);
    chk({tag, " wr_addr"}, wr_addr, ea);
    chk({tag, " wr_data"}, wr_data, d);
    chk({tag, " wr_strb"}, 32'(wr_strb), 32'(es));
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd_reg(8'h0C, v); chk("R1 ctl reset", v, 32'h544F0000);
    rd_reg(8'h00, v); chk("R1 base reset", v, 32'h0);
    rd_reg(8'h08, v); chk("R1 dim reset", v, 32'h0);
    rd_reg(8'h10, v); chk("R1 prog reset", v, 32'h0);
    chk("R1 irq reset", 32'(irq), 32'd0);
    chk("R1 sof reset", 32'(frm_sof), 32'd0);
    chk("R1 wr_valid reset", 32'(wr_valid), 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr_reg(8'h00, 32'h0000_1003);
    rd_reg(8'h00, v); chk("R10 misaligned base kept", v, 32'h1003);
    wr_reg(8'h04, 32'h0000_0024);
    rd_reg(8'h04, v); chk("R2 pitch readback", v, 32'h24);
    wr_reg(8'h08, 32'h0007_0005);
    rd_reg(8'h08, v); chk("R2 dim readback", v, 32'h0007_0005);
    wr_reg(8'h10, 32'hFFFF_FFFF);
    rd_reg(8'h10, v); chk("R2 prog read-only", v, 32'h0);
    wr_reg(8'h0C, 32'h0020_4000);
    rd_reg(8'h0C, v); chk("R2 R8 ctl pdn readback", v, 32'h5460_0000);
    wr_reg(8'h0C, 32'h0020_0001);
    rd_reg(8'h0C, v); chk("R8 start blocked by pdn", v, 32'h5460_0000);
    chk("R8 no sof when powered down", 32'(frm_sof), 32'd0);
    wr_reg(8'h0C, 32'h000F_0000);
  endtask

  task automatic t_idle_pix();
    logic [31:0] v;
    pix_valid = 1'b1; pix_data = 32'hDEAD_BEEF;
    #1;
    chk("R10 idle pixel no write", 32'(wr_valid), 32'd0);
    @(negedge clk);
    pix_valid = 1'b0;
    rd_reg(8'h10, v); chk("R10 idle pixel prog", v, 32'h0);
  endtask

  task automatic t_frame();
    logic [31:0] v;
    wr_reg(8'h00, 32'h0000_1000);
    wr_reg(8'h04, 32'h0000_0040);
    wr_reg(8'h08, 32'h0002_0003);
    wr_reg(8'h0C, 32'h000F_0005);
    chk("R3 sof after start", 32'(frm_sof), 32'd1);
    rd_reg(8'h0C, v); chk("R3 busy after start", v, 32'h544F_0006);
    chk("R7 no irq while busy", 32'(irq), 32'd0);
    @(negedge clk);
    chk("R3 sof one cycle", 32'(frm_sof), 32'd0);
    for (int k = 0; k < 3; k++) begin
      push(32'hA000_0000 + 32'(k), want_addr(32'h1000, 32'h40, 0, k), 4'hF, "R4 line0");
      if (k == 0) @(negedge clk);
    end
    rd_reg(8'h10, v); chk("R5 prog after line0", v, 32'h1);
    wr_reg(8'h0C, 32'h000F_0005);
    chk("R3 restart while busy no sof", 32'(frm_sof), 32'd0);
    rd_reg(8'h10, v); chk("R3 restart while busy prog", v, 32'h1);
    for (int k = 0; k < 3; k++) begin
      push(32'hB000_0000 + 32'(k), want_addr(32'h1000, 32'h40, 1, k), 4'hF, "R4 line1");
      if (k < 2) begin
        rd_reg(8'h0C, v); chk("R5 busy mid line", v & 32'h2, 32'h2);
      end
    end
    rd_reg(8'h0C, v); chk("R5 idle after last line", v & 32'h2, 32'h0);
    rd_reg(8'h10, v); chk("R5 prog equals height", v, 32'h2);
    chk("R5 eof pulse", 32'(frm_eof), 32'd1);
    chk("R9 no repeat sof when bit off", 32'(frm_sof), 32'd0);
    chk("R7 irq at idle", 32'(irq), 32'd1);
    @(negedge clk);
    chk("R5 eof one cycle", 32'(frm_eof), 32'd0);
    wr_reg(8'h0C, 32'h000F_0000);
    chk("R7 irq cleared", 32'(irq), 32'd0);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    wr_reg(8'h00, 32'h0000_2002);
    wr_reg(8'h04, 32'h0000_0024);
    wr_reg(8'h08, 32'h0003_0004);
    wr_reg(8'h0C, 32'h0003_0005);
    for (int k = 0; k < 5; k++)
      push(32'hC000_0000 + 32'(k), want_addr(32'h2002, 32'h24, k / 4, k % 4), 4'h3,
           "R4 R10 misaligned");
    reg_wen = 1'b1; reg_addr = 8'h0C; reg_wdata = 32'h0003_4004;
    pix_valid = 1'b1; pix_data = 32'h1234_5678;
    #1;
    chk("R6 no write in abort cycle", 32'(wr_valid), 32'd0);
    @(negedge clk);
    reg_wen = 1'b0;
    #1;
    chk("R6 no write after abort", 32'(wr_valid), 32'd0);
    pix_valid = 1'b0;
    rd_reg(8'h0C, v); chk("R6 idle after abort", v, 32'h5443_0004);
    rd_reg(8'h10, v); chk("R6 prog held", v, 32'h1);
    chk("R6 no eof on abort", 32'(frm_eof), 32'd0);
    chk("R9 no sof on abort", 32'(frm_sof), 32'd0);
    chk("R7 irq after abort", 32'(irq), 32'd1);
    @(negedge clk);
    wr_reg(8'h0C, 32'h000F_0000);
    chk("R7 irq cleared after abort", 32'(irq), 32'd0);
  endtask

  task automatic t_repeat();
    logic [31:0] v;
    wr_reg(8'h00, 32'h0000_3000);
    wr_reg(8'h04, 32'h0000_0010);
    wr_reg(8'h08, 32'h0001_0002);
    wr_reg(8'h0C, 32'h000F_8001);
    @(negedge clk);
    push(32'h1, want_addr(32'h3000, 32'h10, 0, 0), 4'hF, "R4 repeat frame");
    push(32'h2, want_addr(32'h3000, 32'h10, 0, 1), 4'hF, "R4 repeat frame");
    chk("R9 repeat sof at completion", 32'(frm_sof), 32'd1);
    chk("R9 eof with repeat", 32'(frm_eof), 32'd1);
    rd_reg(8'h0C, v); chk("R9 idle after frame", v & 32'h2, 32'h0);
    chk("R7 no irq when disabled", 32'(irq), 32'd0);
    @(negedge clk);
    wr_reg(8'h0C, 32'h000F_0000);
  endtask

  task automatic t_zero_h();
    logic [31:0] v;
    wr_reg(8'h08, 32'h0000_0002);
    wr_reg(8'h0C, 32'h000F_0001);
    rd_reg(8'h0C, v); chk("R5 zero height busy one cycle", v & 32'h2, 32'h2);
    pix_valid = 1'b1;
    #1;
    chk("R5 zero height no write", 32'(wr_valid), 32'd0);
    @(negedge clk);
    pix_valid = 1'b0;
    rd_reg(8'h0C, v); chk("R5 zero height idle", v & 32'h2, 32'h0);
    chk("R5 zero height eof", 32'(frm_eof), 32'd1);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_idle_pix();
    t_frame();
    t_abort();
    t_repeat();
    t_zero_h();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule